// File: doc/BRIEF.md
# Bidirectional GPIO Port Bank

This block provides sixteen bidirectional digital pins that a small microcontroller reaches through four 8-bit special-function registers. The pins are split into groups of four. One register serves each group: its upper nibble sets the direction of the four pins and its lower nibble holds their output values. Each pin has a data latch, a tri-state driver (shown as a value/enable pair), and an input path made of a two-flop synchronizer.

A global enable input, driven by a configuration register elsewhere in the chip, holds every driver off while it is low. Firmware can therefore load direction and data while the pins stay quiet, and then raise the enable. A read of a register always returns the synchronized live level of the pins, not the latched output values. Software can count pulses on a pin that the bank itself is driving.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every direction latch and data latch is 0, no pin drives (`pin_oe` = 0, `pin_out` = 0) and `sfr_rdata` is 0.
- R2: The register of group g (g = 0..3) is at SFR address 0x80 + 0x10*g and serves pins 4g..4g+3. Bit k of either nibble belongs to pin 4g+k.
- R3: A write strobe to a mapped address loads `sfr_wdata[7:4]` into that group's direction latches and `sfr_wdata[3:0]` into its data latches. The new values take effect in the clock after the strobe.
- R4: `pin_oe[i]` is 1 exactly when pin i's direction bit is 1 (1 = output) and `port_en` is 1. `pin_out[i]` equals pin i's data latch while `pin_oe[i]` is 1, and is 0 otherwise.
- R5: While `port_en` is 0 no pin drives, whatever the direction bits hold. The latches keep their contents, so raising `port_en` drives the stored values with no further write.
- R6: A read strobe to a mapped address gives `sfr_rdata` = {direction latches, synchronized pin levels} of that group one clock later. In the clock after a cycle with no read strobe, or after a read of an unmapped address, `sfr_rdata` is 0.
- R7: Pin inputs pass through two flops. A read strobe in the same cycle as a pin change, or one cycle after it, returns the old level. A read strobe two cycles after the change returns the new level.
- R8: A write to any unmapped address changes no latch, direction or output.
- R9: The data nibble of a read returns the level on `pin_in` even for a pin set as an output whose latch holds a different value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Global driver enable from the configuration register |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe |
| sfr_wdata | input | 8 | Write data: [7:4] direction, [3:0] data |
| sfr_rdata | output | 8 | Read data, valid one clock after the read strobe |
| pin_in | input | 16 | Level seen at each pin |
| pin_out | output | 16 | Value driven on each pin |
| pin_oe | output | 16 | Driver enable per pin |

## Verification
The synchronizer assertion compares a read with the pin level three clocks earlier. It therefore assumes that `pin_in` was 0 through reset and for the first clocks after it. The bench holds all pins low until well after reset is released. The assertions also expect a read strobe to be low in the cycle before reset ends. The bench drives every strobe only at falling edges and keeps them low during and just after reset. The sweep writes all 256 register values to each group with the enable both low and high. It changes `pin_in` only at the falling edge that starts each write, so every later read sees a settled synchronizer.

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int GROUPS = 4,
  parameter int GW = 4,
  parameter logic [7:0] BASE = 8'h80,
  parameter logic [7:0] STRIDE = 8'h10,
  localparam int NPIN = GROUPS * GW,
  localparam int DW = 2 * GW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_en,
  input  logic [7:0]      sfr_addr,
  input  logic            sfr_wr,
  input  logic            sfr_rd,
  input  logic [DW-1:0]   sfr_wdata,
  output logic [DW-1:0]   sfr_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe
);
  logic [NPIN-1:0] dir_q, dat_q, sync1_q, sync2_q;
  logic [GROUPS-1:0] hit;
  logic [DW-1:0] rd_mux;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [7:0] ADDR = 8'(BASE + STRIDE * g);
    assign hit[g] = (sfr_addr == ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[g*GW +: GW] <= '0;
        dat_q[g*GW +: GW] <= '0;
      end else if (sfr_wr && hit[g]) begin
        dir_q[g*GW +: GW] <= sfr_wdata[DW-1:GW];
        dat_q[g*GW +: GW] <= sfr_wdata[GW-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < GROUPS; g++)
      if (hit[g]) rd_mux = rd_mux | {dir_q[g*GW +: GW], sync2_q[g*GW +: GW]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q   <= '0;
      sync2_q   <= '0;
      sfr_rdata <= '0;
    end else begin
      sync1_q   <= pin_in;
      sync2_q   <= sync1_q;
      sfr_rdata <= (sfr_rd && |hit) ? rd_mux : '0;
    end
  end

  assign pin_oe  = dir_q & {NPIN{port_en}};
  assign pin_out = dat_q & pin_oe;
endmodule

module gpio_port_bank_chk #(
  parameter int GW = 4,
  parameter int NPIN = 16,
  parameter logic [7:0] BASE = 8'h80
) (
  input logic            clk,
  input logic            rst_n,
  input logic            port_en,
  input logic [7:0]      sfr_addr,
  input logic            sfr_wr,
  input logic            sfr_rd,
  input logic [2*GW-1:0] sfr_wdata,
  input logic [2*GW-1:0] sfr_rdata,
  input logic [NPIN-1:0] pin_in,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

  assert_write_group0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == BASE) |=>
      (pin_oe[GW-1:0] == ($past(sfr_wdata[2*GW-1:GW]) & {GW{port_en}})));

  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (pin_oe == '0 && pin_out == '0));

  assert_out_only_when_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  assert_idle_rdata_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sfr_rd) |-> sfr_rdata == '0);

  assert_sync_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sfr_rd && sfr_addr == BASE) |-> sfr_rdata[GW-1:0] == $past(pin_in[GW-1:0], 3));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(.GW(GW), .NPIN(NPIN), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .sfr_addr(sfr_addr),
  .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_port_bank_bench.sv
module gpio_port_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, port_en = 0, sfr_wr = 0, sfr_rd = 0;
  logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic [15:0] pin_in = 0, pin_out, pin_oe;
  int checks = 0, failures = 0;
  logic [3:0] m_dir [4];
  logic [3:0] m_dat [4];

  gpio_port_bank u_gpio_port_bank (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sfr_addr(sfr_addr),
    .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
    @(negedge clk); sfr_wr = 0;
  endtask

  task automatic do_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sfr_addr = a; sfr_rd = 1;
    @(negedge clk); sfr_rd = 0; d = sfr_rdata;
  endtask

  function automatic logic [15:0] exp_oe();
    logic [15:0] r;
    for (int g = 0; g < 4; g++) r[g*4 +: 4] = port_en ? m_dir[g] : 4'h0;
    return r;
  endfunction

  function automatic logic [15:0] exp_out();
    logic [15:0] r;
    logic [15:0] oe;
    oe = exp_oe();
    for (int g = 0; g < 4; g++) r[g*4 +: 4] = m_dat[g] & oe[g*4 +: 4];
    return r;
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [15:0] p;
    for (int g = 0; g < 4; g++) begin m_dir[g] = 0; m_dat[g] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 oe", pin_oe, 16'h0);
    chk("R1 out", pin_out, 16'h0);
    chk("R1 rdata", {8'h0, sfr_rdata}, 16'h0);
    port_en = 1;
    do_read(8'h80, rd); chk("R1 dir after reset", {8'h0, rd}, 16'h0);
    chk("R1 oe with enable", pin_oe, 16'h0);

    // R2 R3 R4 R9 sweep: every value, every group, enable low and high
    for (int e = 0; e < 2; e++)
      for (int g = 0; g < 4; g++)
        for (int v = 0; v < 256; v++) begin
          logic [7:0] a;
          a = 8'h80 + 8'(g * 16);
          p = 16'((v * 16'h3B5) ^ (g * 16'h1111) ^ 16'hA5C3);
          @(negedge clk);
          port_en = e[0]; pin_in = p; sfr_addr = a; sfr_wdata = v[7:0]; sfr_wr = 1;
          @(negedge clk); sfr_wr = 0;
          m_dir[g] = v[7:4]; m_dat[g] = v[3:0];
          chk("R4 oe", pin_oe, exp_oe());
          chk("R4 out", pin_out, exp_out());
          // R9: data nibble is the pin level, not the latch
          do_read(a, rd);
          chk("R2 R3 R9 read", {8'h0, rd}, {8'h0, v[7:4], p[g*4 +: 4]});
        end

    // R6 idle cycle returns 0
    @(negedge clk); chk("R6 idle rdata", {8'h0, sfr_rdata}, 16'h0);

    // R5 enable gating with latches kept
    port_en = 0;
    do_write(8'h90, 8'hF6); m_dir[1] = 4'hF; m_dat[1] = 4'h6;
    chk("R5 oe off", pin_oe, 16'h0);
    chk("R5 out off", pin_out, 16'h0);
    @(negedge clk); port_en = 1; #1;
    chk("R5 oe restored", pin_oe, exp_oe());
    chk("R5 out restored", pin_out, exp_out());

    // R8 unmapped writes ignored; R6 unmapped read gives 0
    do_write(8'h81, 8'h00);
    do_write(8'h00, 8'h00);
    do_write(8'hB1, 8'h00);
    do_write(8'hC0, 8'h00);
    chk("R8 oe", pin_oe, exp_oe());
    chk("R8 out", pin_out, exp_out());
    do_read(8'hB0, rd); chk("R8 group3 dir", {12'h0, rd[7:4]}, {12'h0, m_dir[3]});
    pin_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    do_read(8'hC0, rd); chk("R6 unmapped read", {8'h0, rd}, 16'h0);

    // R7 synchronizer depth on group 2
    do_write(8'hA0, 8'h00); m_dir[2] = 0; m_dat[2] = 0;
    pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    sfr_addr = 8'hA0; pin_in = 16'h0500; sfr_rd = 1;
    @(negedge clk); chk("R7 read at change", {8'h0, sfr_rdata}, 16'h0);
    @(negedge clk); chk("R7 read one after", {8'h0, sfr_rdata}, 16'h0);
    @(negedge clk); chk("R7 read two after", {8'h0, sfr_rdata}, 16'h0005);
    sfr_rd = 0;
    @(negedge clk); chk("R6 rdata clears", {8'h0, sfr_rdata}, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule